// File: doc/BRIEF.md
# Arithmetic Status Flag Unit

This block adds or subtracts two operands at a chosen width of 8, 16 or 32 bits and returns the result at that width without delay. On a clock edge where execution is enabled, it captures the condition of that result into a 16-bit flags word. The word holds carry, parity of the low result byte, a nibble carry, zero, sign and signed overflow, each at a fixed bit position. The positions are not contiguous.

The same word also carries three control bits: single-step trap, interrupt enable and string direction. Arithmetic never changes them. They change only through a dedicated load port. The remaining bit positions read as constants, so the word always has one known shape. A pipeline stage would drive the operands and the operation each cycle, raise the execute enable for instructions that write flags, and read the flags word back for conditional decisions.

Top module: `arith_flag_unit`

## Requirements
- R1: `result` is the low N bits of `opa + opb` when `op_sub` = 0, or of `opa - opb` when `op_sub` = 1, with the upper bits zero. N depends on `op_size`: 00 gives 8, 01 gives 16, and 10 or 11 give 32. Only the low N bits of each operand take part.
- R2: Flags bit 0 (carry) is set on addition when a carry leaves bit N-1. On subtraction it is set when the unsigned low-N operand `opb` exceeds `opa`, meaning a borrow is needed.
- R3: Flags bit 2 (parity) is 1 when `result[7:0]` holds an even number of ones, and 0 when that count is odd.
- R4: Flags bit 4 (nibble carry) is set when a carry passes out of bit 3 on addition. On subtraction it is set when `opa[3:0]` < `opb[3:0]`.
- R5: Flags bit 6 (zero) is 1 when the sized result is all zeros. Flags bit 7 (sign) equals bit N-1 of the result.
- R6: Flags bit 11 (overflow) is set on addition when both operands have the same sign and the result has the other sign. On subtraction it is set when the operands differ in sign and the result sign differs from that of `opa`.
- R7: The status bits 0, 2, 4, 6, 7 and 11 are loaded on a rising clock edge only when `exec_en` is 1. Otherwise they hold their value.
- R8: On a rising clock edge with `ctl_load` = 1, flags bits 8 (trap), 9 (interrupt enable) and 10 (direction) take `ctl_wdata[0]`, `[1]` and `[2]`. Otherwise they hold their value, and arithmetic never changes them.
- R9: Flags bit 1 always reads 1. Bits 3, 5 and 12 to 15 always read 0.
- R10: While reset is held, and until the first update after it, the flags word is 0002h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | Capture status flags on this edge |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| op_size | input | 2 | Operand width select (00 = 8, 01 = 16, 1x = 32) |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| ctl_load | input | 1 | Load control bits on this edge |
| ctl_wdata | input | 3 | New control bits {direction, interrupt enable, trap} |
| result | output | 32 | Sized result, zero-extended |
| flags | output | 16 | Flags word |

## Verification
The result comes straight from the operands, so a wrong lane choice or a wrong sign bit at a size boundary shows on `result` in the same cycle. A flag computed wrongly, or written to the wrong bit, shows on `flags` one edge after an enabled operation. A hold failure in either the status bits or the control bits shows one edge after a cycle that should have left them alone. Operations run at every size, in both directions, and across the nibble, sign and carry boundaries, so each such fault has a near-term chance to reach the ports.

// File: rtl/aflag_pkg.sv
package aflag_pkg;
  localparam int DATA_W    = 32;
  localparam int FLAG_W    = 16;
  localparam int MIN_W     = 8;
  localparam int NUM_LANES = $clog2(DATA_W / MIN_W) + 1;
  localparam int SEL_W     = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
  localparam int CTL_W     = 3;

  // bit positions in the flags word
  localparam int FB_CY  = 0;
  localparam int FB_ONE = 1;
  localparam int FB_PAR = 2;
  localparam int FB_NIB = 4;
  localparam int FB_ZR  = 6;
  localparam int FB_SG  = 7;
  localparam int FB_TRP = 8;
  localparam int FB_IEN = 9;
  localparam int FB_DIR = 10;
  localparam int FB_OV  = 11;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_DWORD = 2'b10,
    SZ_WIDE  = 2'b11
  } size_e;

  typedef struct packed {
    logic ov;
    logic sg;
    logic zr;
    logic nib;
    logic par;
    logic cy;
  } stat_t;

  typedef struct packed {
    logic dir;
    logic ien;
    logic trp;
  } ctl_t;
endpackage

// File: rtl/aflag_lane.sv
module aflag_lane #(
  parameter int W = 8
) (
  input  logic         sub,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         carry,
  output logic         ovf,
  output logic         sign
);
  logic [W:0] ext;

  always_comb begin
    if (sub) ext = {1'b0, a} - {1'b0, b};
    else     ext = {1'b0, a} + {1'b0, b};
  end

  assign res   = ext[W-1:0];
  assign carry = ext[W];
  assign sign  = ext[W-1];

  always_comb begin
    if (sub) ovf = (a[W-1] != b[W-1]) && (ext[W-1] != a[W-1]);
    else     ovf = (a[W-1] == b[W-1]) && (ext[W-1] != a[W-1]);
  end
endmodule

// File: rtl/aflag_parity.sv
module aflag_parity #(
  parameter int W = 8
) (
  input  logic [W-1:0] bits,
  output logic         even
);
  logic [W:0] chain;
  assign chain[0] = 1'b1;
  for (genvar k = 0; k < W; k++) begin : g_chain
    assign chain[k+1] = chain[k] ^ bits[k];
  end
  assign even = chain[W];
endmodule

// File: rtl/aflag_alu.sv
module aflag_alu
  import aflag_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int LANES = NUM_LANES,
  parameter int SW    = SEL_W
) (
  input  logic          sub,
  input  logic [1:0]    size,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic [DW-1:0] result,
  output stat_t         stat
);
  logic [DW-1:0] lane_res [LANES];
  logic [LANES-1:0] lane_cy;
  logic [LANES-1:0] lane_ov;
  logic [LANES-1:0] lane_sg;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int LW = MIN_W << i;
    logic [LW-1:0] lr;
    aflag_lane #(.W(LW)) u_lane (
      .sub   (sub),
      .a     (opa[LW-1:0]),
      .b     (opb[LW-1:0]),
      .res   (lr),
      .carry (lane_cy[i]),
      .ovf   (lane_ov[i]),
      .sign  (lane_sg[i])
    );
    assign lane_res[i] = DW'(lr);
  end

  logic [SW-1:0] sel;
  always_comb begin
    unique case (size)
      SZ_BYTE: sel = SW'(0);
      SZ_WORD: sel = SW'(1);
      default: sel = SW'(LANES - 1);
    endcase
    if (int'(sel) > LANES - 1) sel = SW'(LANES - 1);
  end

  logic [4:0] nib;
  always_comb begin
    if (sub) nib = {1'b0, opa[3:0]} - {1'b0, opb[3:0]};
    else     nib = {1'b0, opa[3:0]} + {1'b0, opb[3:0]};
  end

  logic par_even;
  aflag_parity #(.W(MIN_W)) u_par (
    .bits (result[MIN_W-1:0]),
    .even (par_even)
  );

  assign result = lane_res[sel];

  always_comb begin
    stat.cy  = lane_cy[sel];
    stat.ov  = lane_ov[sel];
    stat.sg  = lane_sg[sel];
    stat.zr  = (result == '0);
    stat.par = par_even;
    stat.nib = nib[4];
  end
endmodule

// File: rtl/aflag_regs.sv
module aflag_regs
  import aflag_pkg::*;
#(
  parameter int FW = FLAG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_en,
  input  stat_t         stat_in,
  input  logic          ctl_load,
  input  ctl_t          ctl_in,
  output logic [FW-1:0] flags
);
  stat_t stat_q, stat_d;
  ctl_t  ctl_q, ctl_d;

  always_comb begin
    stat_d = stat_q;
    if (exec_en) stat_d = stat_in;
  end

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_load) ctl_d = ctl_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      ctl_q  <= '0;
    end else begin
      stat_q <= stat_d;
      ctl_q  <= ctl_d;
    end
  end

  always_comb begin
    flags         = '0;
    flags[FB_ONE] = 1'b1;
    flags[FB_CY]  = stat_q.cy;
    flags[FB_PAR] = stat_q.par;
    flags[FB_NIB] = stat_q.nib;
    flags[FB_ZR]  = stat_q.zr;
    flags[FB_SG]  = stat_q.sg;
    flags[FB_OV]  = stat_q.ov;
    flags[FB_TRP] = ctl_q.trp;
    flags[FB_IEN] = ctl_q.ien;
    flags[FB_DIR] = ctl_q.dir;
  end
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
  import aflag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_en,
  input  logic              op_sub,
  input  logic [1:0]        op_size,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              ctl_load,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags
);
  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  stat_t stat_w;
  ctl_t  ctl_w;
  assign ctl_w = ctl_t'(ctl_wdata);

  aflag_alu u_alu (
    .sub    (op_sub),
    .size   (op_size),
    .opa    (opa),
    .opb    (opb),
    .result (result),
    .stat   (stat_w)
  );

  aflag_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .exec_en  (exec_en),
    .stat_in  (stat_w),
    .ctl_load (ctl_load),
    .ctl_in   (ctl_w),
    .flags    (flags)
  );
endmodule

// File: rtl/aflag_chk.sv
module aflag_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        exec_en,
  input logic        ctl_load,
  input logic [2:0]  ctl_wdata,
  input logic [31:0] result,
  input logic [15:0] flags
);
  p_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[15:12] == 4'h0) && !flags[5] && !flags[3] && flags[1]);

  p_status_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |=> $stable({flags[11], flags[7:6], flags[4], flags[2], flags[0]}));

  p_ctl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_load |=> $stable(flags[10:8]));

  p_ctl_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_load |=> flags[10:8] == $past(ctl_wdata));

  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en |=> flags[6] == ($past(result) == 32'h0));

  p_parity_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en |=> flags[2] == ~(^$past(result[7:0])));
endmodule

bind arith_flag_unit aflag_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .exec_en   (exec_en),
  .ctl_load  (ctl_load),
  .ctl_wdata (ctl_wdata),
  .result    (result),
  .flags     (flags)
);

// File: tb/sim_arith_flag_unit.sv
`timescale 1ns/1ps
module sim_arith_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exec_en, op_sub, ctl_load;
  logic [1:0]  op_size;
  logic [31:0] opa, opb, result;
  logic [2:0]  ctl_wdata;
  logic [15:0] flags;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [5:0]  exp_st;   // {ov,sg,zr,nib,par,cy}
  logic [2:0]  exp_ctl;  // {dir,ien,trp}

  always #10 clk = ~clk;

  arith_flag_unit u0 (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_sub(op_sub),
    .op_size(op_size), .opa(opa), .opb(opb), .ctl_load(ctl_load),
    .ctl_wdata(ctl_wdata), .result(result), .flags(flags)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int width_of(logic [1:0] sz);
    return (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
  endfunction

  function automatic logic [31:0] ref_res(logic sub, logic [1:0] sz, logic [31:0] a, logic [31:0] b);
    longint unsigned m, r;
    int w = width_of(sz);
    m = (64'd1 << w) - 1;
    r = sub ? ((a & m) - (b & m)) : ((a & m) + (b & m));
    return 32'(r & m);
  endfunction

  function automatic logic [5:0] ref_st(logic sub, logic [1:0] sz, logic [31:0] a, logic [31:0] b);
    longint unsigned m, am, bm, full;
    logic [31:0] r;
    logic cy, par, nib, zr, sg, ov, sa, sb;
    int ones = 0;
    int w = width_of(sz);
    m = (64'd1 << w) - 1;
    am = a & m; bm = b & m;
    r = ref_res(sub, sz, a, b);
    if (sub) begin
      cy  = am < bm;
      nib = (a & 32'hF) < (b & 32'hF);
    end else begin
      full = am + bm;
      cy  = full[w];
      nib = ((a & 32'hF) + (b & 32'hF)) > 15;
    end
    for (int k = 0; k < 8; k++) ones += int'(r[k]);
    par = (ones % 2) == 0;
    zr  = (r == 0);
    sg  = r[w-1];
    sa  = a[w-1]; sb = b[w-1];
    ov  = sub ? ((sa != sb) && (sg != sa)) : ((sa == sb) && (sg != sa));
    return {ov, sg, zr, nib, par, cy};
  endfunction

  function automatic logic [15:0] word(logic [5:0] st, logic [2:0] c);
    return {4'h0, st[5], c[2], c[1], c[0], st[4], st[3], 1'b0, st[2], 1'b0, st[1], 1'b1, st[0]};
  endfunction

  task automatic check_flags();
    check("R2 carry",   32'(flags[0]),  32'(exp_st[0]));
    check("R3 parity",  32'(flags[2]),  32'(exp_st[1]));
    check("R4 nibble",  32'(flags[4]),  32'(exp_st[2]));
    check("R5 zero",    32'(flags[6]),  32'(exp_st[3]));
    check("R5 sign",    32'(flags[7]),  32'(exp_st[4]));
    check("R6 overflow",32'(flags[11]), 32'(exp_st[5]));
    check("R8 control", 32'(flags[10:8]), 32'(exp_ctl));
    check("R9 fixed",   32'({flags[15:12], flags[5], flags[3], flags[1]}), 32'(7'b0000001));
  endtask

  // called at a falling edge; returns at a falling edge
  task automatic run_op(logic sub, logic [1:0] sz, logic [31:0] a, logic [31:0] b, logic en);
    op_sub = sub; op_size = sz; opa = a; opb = b; exec_en = en;
    #5;
    check("R1 result", result, ref_res(sub, sz, a, b));
    @(posedge clk);
    @(negedge clk);
    if (en) exp_st = ref_st(sub, sz, a, b);
    else    check("R7 hold", 32'(flags), 32'(word(exp_st, exp_ctl)));
    exec_en = 1'b0;
    check_flags();
  endtask

  task automatic load_ctl(logic [2:0] v);
    ctl_load = 1'b1; ctl_wdata = v;
    @(posedge clk);
    @(negedge clk);
    ctl_load = 1'b0; ctl_wdata = 3'b000;
    exp_ctl = v;
    check("R8 load", 32'(flags[10:8]), 32'(v));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; exec_en = 0; op_sub = 0; op_size = 0;
    opa = 0; opb = 0; ctl_load = 0; ctl_wdata = 0;
    exp_st = '0; exp_ctl = '0;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check("R10 reset word", 32'(flags), 32'h0002);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 after release", 32'(flags), 32'h0002);

    // directed corners
    run_op(1'b0, 2'b00, 32'h80, 32'h80, 1'b1);
    check("R6 80h+80h word", 32'(flags), 32'h0847);
    run_op(1'b0, 2'b01, 32'hFFFF, 32'hFFFE, 1'b1);
    check("R5 word add word", 32'(flags), 32'h0093);
    run_op(1'b1, 2'b10, 32'h0, 32'h1, 1'b1);
    check("R2 borrow word", 32'(flags), 32'h0097);
    run_op(1'b1, 2'b11, 32'h8000_0000, 32'h1, 1'b1);
    run_op(1'b0, 2'b00, 32'hFFFF_FF7F, 32'h0000_0001, 1'b1);
    run_op(1'b0, 2'b01, 32'h0000_7FFF, 32'h0000_0001, 1'b1);
    run_op(1'b1, 2'b00, 32'h10, 32'h01, 1'b1);
    run_op(1'b1, 2'b01, 32'h1234, 32'h1234, 1'b1);

    // R7: disabled ops leave status alone
    run_op(1'b0, 2'b10, 32'hFFFF_FFFF, 32'h1, 1'b0);
    run_op(1'b1, 2'b00, 32'h00, 32'h7F, 1'b0);

    // R8: control loads, arithmetic does not disturb them
    load_ctl(3'b101);
    run_op(1'b0, 2'b10, 32'h7FFF_FFFF, 32'h1, 1'b1);
    load_ctl(3'b010);
    load_ctl(3'b111);
    run_op(1'b1, 2'b10, 32'h5, 32'h5, 1'b1);
    load_ctl(3'b000);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] ra, rb;
      logic [1:0]  rs;
      ra = $urandom; rb = $urandom; rs = 2'($urandom);
      if (n % 5 == 0) begin ra = ra & 32'h8000_008F; rb = rb & 32'h8000_008F; end
      if (n % 37 == 0) load_ctl(3'($urandom));
      run_op(1'($urandom), rs, ra, rb, ($urandom % 4) != 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule